// File: doc/BRIEF.md
# Masked Associative Compare Engine

This block is the search core of a small content-addressable memory. It stores one 64-bit search key (the comparand), two 64-bit mask words and a table of 64-bit entries, each with its own valid bit. All storage is loaded one 16-bit segment at a time through a simple write strobe. When a compare runs, every valid entry is checked against the comparand in parallel. The check is either exact or ignores the bit positions set in one of the two masks. The block then reports whether anything matched and the index of the lowest matching entry.

A compare does not need a separate start command. Writing the highest segment of the comparand or of either mask starts one. A configuration write from the host that is not a clear request also starts one. The match indication can be disabled by configuration so that the device drops out of a daisy chain. The external match flag is driven only while the chain enable input is low.

Top module: `cam_cmp_engine`

## Requirements
- R1: A write with `seg_sel` = 3 to the comparand (`seg_tgt` = 0), mask 1 (`seg_tgt` = 1) or mask 2 (`seg_tgt` = 2) triggers a compare. New results appear after the second rising edge that follows the strobe cycle, not after the first. Writes to segments 0 to 2, entry writes (`seg_tgt` = 3) and valid-bit writes trigger no compare.
- R2: A pulse on `cfg_we` with `cfg_run` = 1 triggers a compare with the same one-clock latency.
- R3: Entries whose valid bit is 0 never match.
- R4: `mask_sel` = 1 makes the compare ignore the bit positions set in mask 1, and `mask_sel` = 2 does the same with mask 2. Values 0 and 3 give an exact 64-bit compare. The value used is the one present on the edge that latches the result.
- R5: When several valid entries match, `hit_addr` reports the lowest index. On a miss, `hit_n` is 1 and `hit_addr` is 0.
- R6: If `flag_cfg` is not 2'b00 on the result edge, `hit_n` is forced to 1 even when an entry matches. `hit_addr` still reports the lowest match.
- R7: `match_flag_n` equals `hit_n` while `chain_en_n` is 0, and is 1 while `chain_en_n` is 1.
- R8: A pulse on `cfg_we` with `cfg_run` = 0 runs no compare. After the next edge it clears every valid bit and sets `hit_n` to 1 and `hit_addr` to 0.
- R9: After reset, `hit_n` and `match_flag_n` are 1, `hit_addr` is 0, all registers are zero and no entry is valid.
- R10: `hit_n` and `hit_addr` hold their values between compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment write strobe |
| seg_tgt | input | 2 | Write target: 0 comparand, 1 mask 1, 2 mask 2, 3 table entry |
| seg_sel | input | 2 | Segment index, 0 = bits 15:0, 3 = bits 63:48 |
| seg_wdata | input | 16 | Segment write data |
| ent_addr | input | 4 | Entry index for entry and valid writes |
| vld_we | input | 1 | Valid-bit write strobe |
| vld_wdata | input | 1 | Valid-bit value |
| cfg_we | input | 1 | Configuration write pulse |
| cfg_run | input | 1 | 1: compare request, 0: clear request |
| mask_sel | input | 2 | Mask selection for the compare |
| flag_cfg | input | 2 | 2'b00 enables the match indication, any other value disables it |
| chain_en_n | input | 1 | Active-low daisy-chain enable for the match flag |
| hit_n | output | 1 | Internal active-low match condition |
| match_flag_n | output | 1 | Active-low match flag output |
| hit_addr | output | 4 | Lowest matching entry index |

## Verification
A wrong mask select, a stale valid bit or a broken priority chain shows up as a wrong `hit_addr` or `hit_n` one clock after the trigger. The vector sweep covers duplicate entries, invalid entries and each mask setting, so these faults are caught at the first compare that depends on them. A trigger that fires too early or not at all shows as a result that changes one edge early or never changes. The bench samples both edges after each strobe to catch this. Corrupted key or table storage becomes visible only at the next compare that reads the damaged bits.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned SEG_W     = 16;
    localparam int unsigned SEGS      = WORD_W / SEG_W;
    localparam int unsigned SEG_SEL_W = $clog2(SEGS);

    typedef enum logic [1:0] {
        TGT_CMP  = 2'd0,
        TGT_MSK1 = 2'd1,
        TGT_MSK2 = 2'd2,
        TGT_ENT  = 2'd3
    } seg_tgt_e;

    typedef enum logic [1:0] {
        MSEL_NONE = 2'd0,
        MSEL_M1   = 2'd1,
        MSEL_M2   = 2'd2,
        MSEL_RSVD = 2'd3
    } msel_e;

    typedef struct packed {
        logic [WORD_W-1:0] cmp;
        logic [WORD_W-1:0] m1;
        logic [WORD_W-1:0] m2;
    } key_t;

    function automatic logic masked_eq(input logic [WORD_W-1:0] word,
                                       input key_t k,
                                       input logic [1:0] sel);
        logic [WORD_W-1:0] ign;
        case (sel)
            MSEL_M1: ign = k.m1;
            MSEL_M2: ign = k.m2;
            default: ign = '0;
        endcase
        return ((word ^ k.cmp) & ~ign) == '0;
    endfunction

endpackage

// File: rtl/cam_key_regs.sv
module cam_key_regs
    import cam_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seg_we,
    input  logic [1:0]           seg_tgt,
    input  logic [SEG_SEL_W-1:0] seg_sel,
    input  logic [SEG_W-1:0]     seg_wdata,
    output key_t                 key,
    output logic                 last_seg_trig
);

    key_t key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (seg_we) begin
            case (seg_tgt)
                TGT_CMP:  key_q.cmp[seg_sel*SEG_W +: SEG_W] <= seg_wdata;
                TGT_MSK1: key_q.m1[seg_sel*SEG_W +: SEG_W]  <= seg_wdata;
                TGT_MSK2: key_q.m2[seg_sel*SEG_W +: SEG_W]  <= seg_wdata;
                default:  ;
            endcase
        end
    end

    assign key           = key_q;
    assign last_seg_trig = seg_we && (seg_tgt != TGT_ENT)
                           && (seg_sel == SEG_SEL_W'(SEGS - 1));

endmodule

// File: rtl/cam_entry_table.sv
module cam_entry_table
    import cam_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned AW      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seg_we,
    input  logic [1:0]           seg_tgt,
    input  logic [SEG_SEL_W-1:0] seg_sel,
    input  logic [SEG_W-1:0]     seg_wdata,
    input  logic [AW-1:0]        ent_addr,
    input  logic                 vld_we,
    input  logic                 vld_wdata,
    input  logic                 vld_clr,
    output logic [WORD_W-1:0]    words [ENTRIES],
    output logic [ENTRIES-1:0]   valid
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [WORD_W-1:0] word_q;
        logic              vld_q;
        logic              sel_here;

        assign sel_here = (ent_addr == AW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (seg_we && seg_tgt == TGT_ENT && sel_here)
                    word_q[seg_sel*SEG_W +: SEG_W] <= seg_wdata;
                if (vld_clr)
                    vld_q <= 1'b0;
                else if (vld_we && sel_here)
                    vld_q <= vld_wdata;
            end
        end

        assign words[g] = word_q;
        assign valid[g] = vld_q;
    end

endmodule

// File: rtl/cam_match_prio.sv
module cam_match_prio
    import cam_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned AW      = 4
) (
    input  logic [WORD_W-1:0]  words [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  key_t               key,
    input  logic [1:0]         msel,
    output logic               any_hit,
    output logic [AW-1:0]      first_idx
);

    logic [ENTRIES-1:0] hitv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hitv[g] = valid[g] && masked_eq(words[g], key, msel);
    end

    always_comb begin
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) first_idx = AW'(i);
        end
    end

    assign any_hit = |hitv;

endmodule

// File: rtl/cam_cmp_engine.sv
module cam_cmp_engine
    import cam_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seg_we,
    input  logic [1:0]           seg_tgt,
    input  logic [SEG_SEL_W-1:0] seg_sel,
    input  logic [SEG_W-1:0]     seg_wdata,
    input  logic [AW-1:0]        ent_addr,
    input  logic                 vld_we,
    input  logic                 vld_wdata,
    input  logic                 cfg_we,
    input  logic                 cfg_run,
    input  logic [1:0]           mask_sel,
    input  logic [1:0]           flag_cfg,
    input  logic                 chain_en_n,
    output logic                 hit_n,
    output logic                 match_flag_n,
    output logic [AW-1:0]        hit_addr
);

    key_t               key;
    logic               last_seg_trig;
    logic [WORD_W-1:0]  words [ENTRIES];
    logic [ENTRIES-1:0] valid;
    logic               any_hit;
    logic [AW-1:0]      first_idx;
    logic               soft_clr;
    logic               cmp_trig;
    logic               cmp_pend;
    logic               hit_n_q;
    logic [AW-1:0]      addr_q;

    assign soft_clr = cfg_we && !cfg_run;
    assign cmp_trig = last_seg_trig || (cfg_we && cfg_run);

    cam_key_regs u_keys (
        .clk           (clk),
        .rst           (rst),
        .seg_we        (seg_we),
        .seg_tgt       (seg_tgt),
        .seg_sel       (seg_sel),
        .seg_wdata     (seg_wdata),
        .key           (key),
        .last_seg_trig (last_seg_trig)
    );

    cam_entry_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
        .clk       (clk),
        .rst       (rst),
        .seg_we    (seg_we),
        .seg_tgt   (seg_tgt),
        .seg_sel   (seg_sel),
        .seg_wdata (seg_wdata),
        .ent_addr  (ent_addr),
        .vld_we    (vld_we),
        .vld_wdata (vld_wdata),
        .vld_clr   (soft_clr),
        .words     (words),
        .valid     (valid)
    );

    cam_match_prio #(.ENTRIES(ENTRIES), .AW(AW)) u_prio (
        .words     (words),
        .valid     (valid),
        .key       (key),
        .msel      (mask_sel),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_pend <= 1'b0;
            hit_n_q  <= 1'b1;
            addr_q   <= '0;
        end else begin
            cmp_pend <= cmp_trig;
            if (soft_clr) begin
                hit_n_q <= 1'b1;
                addr_q  <= '0;
            end else if (cmp_pend) begin
                hit_n_q <= !(any_hit && flag_cfg == 2'b00);
                addr_q  <= any_hit ? first_idx : '0;
            end
        end
    end

    assign hit_n        = hit_n_q;
    assign hit_addr     = addr_q;
    assign match_flag_n = chain_en_n || hit_n_q;

endmodule

// File: rtl/cam_cmp_sva.sv
module cam_cmp_sva #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          seg_we,
    input logic [1:0]    seg_tgt,
    input logic [1:0]    seg_sel,
    input logic          cfg_we,
    input logic          cfg_run,
    input logic [1:0]    flag_cfg,
    input logic          chain_en_n,
    input logic          pend,
    input logic          hit_n,
    input logic          match_flag_n,
    input logic [AW-1:0] hit_addr
);

    assert_last_seg_trig_R1: assert property (@(posedge clk) disable iff (rst)
        (seg_we && seg_tgt != 2'd3 && seg_sel == 2'd3) |=> pend);

    assert_entry_no_trig_R1: assert property (@(posedge clk) disable iff (rst)
        (seg_we && seg_tgt == 2'd3 && !cfg_we) |=> !pend);

    assert_cfg_trig_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_run) |=> pend);

    assert_flag_off_R6: assert property (@(posedge clk) disable iff (rst)
        (pend && flag_cfg != 2'b00 && !cfg_we) |=> hit_n);

    assert_chain_gate_R7: assert property (@(posedge clk) disable iff (rst)
        chain_en_n |-> match_flag_n);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_run) |=> (hit_n && hit_addr == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!pend && !cfg_we) |=> ($stable(hit_n) && $stable(hit_addr)));

endmodule

bind cam_cmp_engine cam_cmp_sva #(.AW(AW)) i_sva (
    .clk          (clk),
    .rst          (rst),
    .seg_we       (seg_we),
    .seg_tgt      (seg_tgt),
    .seg_sel      (seg_sel),
    .cfg_we       (cfg_we),
    .cfg_run      (cfg_run),
    .flag_cfg     (flag_cfg),
    .chain_en_n   (chain_en_n),
    .pend         (cmp_pend),
    .hit_n        (hit_n),
    .match_flag_n (match_flag_n),
    .hit_addr     (hit_addr)
);

// File: tb/test_cam_cmp_engine.sv
module test_cam_cmp_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        seg_we, vld_we, vld_wdata, cfg_we, cfg_run, chain_en_n;
    logic [1:0]  seg_tgt, seg_sel, mask_sel, flag_cfg;
    logic [15:0] seg_wdata;
    logic [3:0]  ent_addr;
    logic        hit_n, match_flag_n;
    logic [3:0]  hit_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    cam_cmp_engine #(.ENTRIES(16)) i_cam_cmp_engine (
        .clk(clk), .rst(rst), .seg_we(seg_we), .seg_tgt(seg_tgt),
        .seg_sel(seg_sel), .seg_wdata(seg_wdata), .ent_addr(ent_addr),
        .vld_we(vld_we), .vld_wdata(vld_wdata), .cfg_we(cfg_we),
        .cfg_run(cfg_run), .mask_sel(mask_sel), .flag_cfg(flag_cfg),
        .chain_en_n(chain_en_n), .hit_n(hit_n),
        .match_flag_n(match_flag_n), .hit_addr(hit_addr)
    );

    typedef struct packed {
        logic [63:0] cmp;
        logic [1:0]  msel;
        logic        hit;
        logic [3:0]  addr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'hCAFE_0000_1234_0005, 2'd0, 1'b1, 4'd5},
        '{64'hCAFE_0000_1234_0003, 2'd0, 1'b1, 4'd3},
        '{64'hCAFE_0000_1234_000E, 2'd0, 1'b0, 4'd0},
        '{64'hCAFE_0000_1234_0009, 2'd0, 1'b0, 4'd0},
        '{64'hCAFE_0000_1234_000B, 2'd1, 1'b1, 4'd3},
        '{64'h0000_0000_1234_0007, 2'd2, 1'b1, 4'd7},
        '{64'h0000_0000_1234_0007, 2'd0, 1'b0, 4'd0},
        '{64'h0000_0000_1234_0007, 2'd3, 1'b0, 4'd0},
        '{64'h0000_0000_1234_0007, 2'd1, 1'b0, 4'd0}
    };

    function automatic logic [63:0] ent_val(input int i);
        if (i == 9) return 64'hCAFE_0000_1234_0003;
        return 64'hCAFE_0000_1234_0000 | 64'(i);
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] tgt, input logic [1:0] sel,
                          input logic [15:0] d);
        @(negedge clk);
        seg_we = 1'b1; seg_tgt = tgt; seg_sel = sel; seg_wdata = d;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic wr_word(input logic [1:0] tgt, input logic [63:0] w);
        for (int s = 0; s < 4; s++) wr_seg(tgt, 2'(s), w[s*16 +: 16]);
    endtask

    task automatic wr_vld(input logic [3:0] a, input logic v);
        @(negedge clk);
        vld_we = 1'b1; ent_addr = a; vld_wdata = v;
        @(negedge clk);
        vld_we = 1'b0;
    endtask

    task automatic cfg_pulse(input logic run);
        @(negedge clk);
        cfg_we = 1'b1; cfg_run = run;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_res(input logic exp_hit, input logic [3:0] exp_addr,
                           input string req);
        chk(hit_n == !exp_hit, req, 64'(hit_n), 64'(!exp_hit));
        chk(hit_addr == exp_addr, req, 64'(hit_addr), 64'(exp_addr));
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        chk(1'b0, "WATCHDOG", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; seg_we = 0; seg_tgt = 0; seg_sel = 0; seg_wdata = 0;
        ent_addr = 0; vld_we = 0; vld_wdata = 0; cfg_we = 0; cfg_run = 0;
        mask_sel = 0; flag_cfg = 0; chain_en_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk_res(1'b0, 4'd0, "R9 reset");
        chk(match_flag_n == 1'b1, "R9 flag", 64'(match_flag_n), 64'd1);
        // R9/R3: zero comparand vs zero entries, none valid yet
        cfg_pulse(1'b1);
        @(negedge clk);
        chk_res(1'b0, 4'd0, "R9 R3 no valid after reset");

        // load table: entries 0..11 valid, 12..15 invalid
        for (int i = 0; i < 16; i++) begin
            ent_addr = 4'(i);
            wr_word(2'd3, ent_val(i));
            wr_vld(4'(i), i < 12);
        end
        wr_word(2'd1, 64'h0000_0000_0000_0008);
        wr_word(2'd2, 64'hFFFF_0000_0000_0000);
        @(negedge clk);

        // vector sweep: R3 R4 R5 R7
        for (int v = 0; v < NV; v++) begin
            mask_sel = VECS[v].msel;
            wr_word(2'd0, VECS[v].cmp);
            @(negedge clk);
            chk_res(VECS[v].hit, VECS[v].addr, $sformatf("R3 R4 R5 vec%0d", v));
            chk(match_flag_n == !VECS[v].hit, "R7 flag follows",
                64'(match_flag_n), 64'(!VECS[v].hit));
        end

        // R1 timing and lower segments
        mask_sel = 2'd0;
        wr_seg(2'd0, 2'd0, 16'h0005);
        wr_seg(2'd0, 2'd1, 16'h1234);
        wr_seg(2'd0, 2'd2, 16'h0000);
        @(negedge clk);
        chk_res(1'b0, 4'd0, "R1 R10 lower segs no trigger");
        wr_seg(2'd0, 2'd3, 16'hCAFE);
        chk_res(1'b0, 4'd0, "R1 not after first edge");
        @(negedge clk);
        chk_res(1'b1, 4'd5, "R1 after second edge");

        // R1: entry and valid writes do not trigger
        wr_seg(2'd0, 2'd0, 16'h0006);
        ent_addr = 4'd13;
        wr_seg(2'd3, 2'd0, 16'h0006);
        wr_vld(4'd12, 1'b1);
        @(negedge clk);
        chk_res(1'b1, 4'd5, "R1 R10 entry write no trigger");

        // R2: configuration write triggers
        cfg_pulse(1'b1);
        @(negedge clk);
        chk_res(1'b1, 4'd6, "R2 cfg compare");

        // R1: mask last segment triggers
        wr_seg(2'd0, 2'd0, 16'h0008);
        wr_seg(2'd1, 2'd3, 16'h0000);
        @(negedge clk);
        chk_res(1'b1, 4'd8, "R1 mask last seg trigger");

        // R6: match indication disabled
        flag_cfg = 2'b01;
        cfg_pulse(1'b1);
        @(negedge clk);
        chk_res(1'b0, 4'd8, "R6 disabled");
        chk(match_flag_n == 1'b1, "R6 flag", 64'(match_flag_n), 64'd1);
        flag_cfg = 2'b00;
        cfg_pulse(1'b1);
        @(negedge clk);
        chk_res(1'b1, 4'd8, "R6 re-enabled");

        // R7: chain enable gating
        chain_en_n = 1'b1;
        #1;
        chk(match_flag_n == 1'b1, "R7 chain off", 64'(match_flag_n), 64'd1);
        chain_en_n = 1'b0;
        #1;
        chk(match_flag_n == 1'b0, "R7 chain on", 64'(match_flag_n), 64'd0);

        // R8: clear request
        cfg_pulse(1'b0);
        chk_res(1'b0, 4'd0, "R8 clear");
        @(negedge clk);
        chk_res(1'b0, 4'd0, "R8 no compare");
        cfg_pulse(1'b1);
        @(negedge clk);
        chk_res(1'b0, 4'd0, "R8 valid cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule